// File: doc/BRIEF.md
# Two-Source Byte Permute Unit

This block assembles a wide result vector one byte lane at a time. Each lane of the result has its own control byte, taken from the same lane of a control vector. That control byte either picks any byte from the concatenation of two source vectors or forces a fixed constant into the lane. A single operation can therefore reverse byte order, merge fields from two registers, or take an unaligned 16-byte window that straddles two aligned words.

The datapath is purely combinational. A parameter can add one register stage at the output. Lane 0 is the most significant byte of every vector. Source indices 0..N-1 address the first source and N..2N-1 address the second.

Top module: `byte_permute2`

## Requirements
- R1: For a control byte with bit 7 clear, the result lane equals byte (ctrl[4:0]) of the 32-byte concatenation {src_a, src_b}. Index 0 is the MSB of src_a and index 16 is the MSB of src_b. Bits 6:5 are ignored.
- R2: A control byte matching 10xxxxxx forces the result lane to 0x00.
- R3: A control byte matching 110xxxxx forces the result lane to 0xFF.
- R4: A control byte matching 111xxxxx forces the result lane to 0x80.
- R5: Each result lane depends only on its own control byte. Changing one control lane leaves all other result lanes unchanged.
- R6: A control vector whose lane i holds 15-i produces src_a with its byte order reversed.
- R7: A control vector whose lane i holds k+i (0 ≤ k ≤ 16) produces the 16-byte window that starts at byte k of {src_a, src_b}.
- R8: With OUT_REG=0 the result follows the inputs in the same cycle. With OUT_REG=1 the result appears one clock after the inputs are sampled, and reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when OUT_REG=1 |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| src_a | input | 128 | First source vector (indices 0..15) |
| src_b | input | 128 | Second source vector (indices 16..31) |
| ctrl | input | 128 | One control byte per result lane |
| result | output | 128 | Permuted result vector |

## Verification
A fault in one lane's selector or constant decoder shows up only in the matching result byte. It appears in the same cycle, or one clock later when the output register is enabled. The bench therefore compares all sixteen lanes on every vector and checks each constant code on every lane. Lane-independence faults, such as an index taken from the wrong control lane, show up when a single control byte changes and a neighbouring result byte moves.

// File: rtl/byte_permute2_pkg.sv
package byte_permute2_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      SEL_SRC  = 2'd0,
      SEL_ZERO = 2'd1,
      SEL_ONES = 2'd2,
      SEL_HALF = 2'd3
   } sel_kind_e;

   typedef struct packed {
      sel_kind_e  kind;
      logic [4:0] idx;
   } lane_sel_t;

   function automatic lane_sel_t decode_ctrl(input logic [7:0] c);
      lane_sel_t s;
      s.idx = c[4:0];
      if (!c[7])     s.kind = SEL_SRC;
      else if (!c[6]) s.kind = SEL_ZERO;
      else if (!c[5]) s.kind = SEL_ONES;
      else           s.kind = SEL_HALF;
      return s;
   endfunction
endpackage

// File: rtl/permute_lane.sv
module permute_lane
   import byte_permute2_pkg::*;
#(
   parameter int LANES = 16,
   localparam int POOL = 2 * LANES,
   localparam int IW = $clog2(POOL)
) (
   input  logic [POOL*BYTE_W-1:0] pool,
   input  logic [BYTE_W-1:0]      ctrl_byte,
   output logic [BYTE_W-1:0]      lane_out
);
   lane_sel_t        sel;
   logic [BYTE_W-1:0] picked;
   logic [IW-1:0]     idx;

   always_comb begin
      sel = decode_ctrl(ctrl_byte);
      idx = sel.idx[IW-1:0];
   end

   // pool byte 0 sits at the most significant end
   always_comb begin
      picked = '0;
      for (int j = 0; j < POOL; j++)
         if (idx == IW'(j))
            picked = pool[(POOL-1-j)*BYTE_W +: BYTE_W];
   end

   always_comb begin
      unique case (sel.kind)
         SEL_SRC:  lane_out = picked;
         SEL_ZERO: lane_out = 8'h00;
         SEL_ONES: lane_out = 8'hFF;
         SEL_HALF: lane_out = 8'h80;
         default:  lane_out = 8'h00;
      endcase
   end

   // R2/R3/R4: constant codes reach the lane output
   always_comb begin
      if (ctrl_byte[7:6] == 2'b10)  p_zero_code_r2: assert (lane_out == 8'h00);
      if (ctrl_byte[7:5] == 3'b110) p_ones_code_r3: assert (lane_out == 8'hFF);
      if (ctrl_byte[7:5] == 3'b111) p_half_code_r4: assert (lane_out == 8'h80);
   end
endmodule

// File: rtl/byte_permute2.sv
module byte_permute2
   import byte_permute2_pkg::*;
#(
   parameter int LANES   = 16,
   parameter bit OUT_REG = 1'b0,
   localparam int VEC_W  = LANES * BYTE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [VEC_W-1:0] ctrl,
   output logic [VEC_W-1:0] result
);
   initial begin
      p_lanes_fit_index: assert (LANES == 16)
         else $error("five-bit index requires exactly 16 lanes per source");
   end

   logic [2*VEC_W-1:0] pool;
   logic [VEC_W-1:0]   comb_res;

   assign pool = {src_a, src_b};

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int HI = (LANES-1-g) * BYTE_W;
      permute_lane #(.LANES(LANES)) u_lane (
         .pool      (pool),
         .ctrl_byte (ctrl[HI +: BYTE_W]),
         .lane_out  (comb_res[HI +: BYTE_W])
      );
   end

   if (OUT_REG) begin : g_reg
      logic [VEC_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) q <= '0;
         else        q <= comb_res;
      assign result = q;

      // R8: registered output lags the combinational result by one clock
      p_reg_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> result == $past(comb_res));
   end else begin : g_comb
      assign result = comb_res;
      // R1: lane 0 with a source code takes byte ctrl[4:0] of the pool
      always_comb
         if (!ctrl[VEC_W-1])
            p_lane0_pick_r1: assert (result[VEC_W-1 -: BYTE_W] ==
               pool[(2*LANES-1-int'(ctrl[VEC_W-4 -: 5]))*BYTE_W +: BYTE_W]);
   end
endmodule

// File: tb/byte_permute2_bench.sv
module byte_permute2_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 128;

   logic clk = 0, rst_n = 0;
   logic [W-1:0] src_a, src_b, ctrl;
   logic [W-1:0] res_c, res_r;
   int n_cmp = 0, n_bad = 0;
   int seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   byte_permute2 #(.OUT_REG(1'b0)) u_byte_permute2 (
      .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .ctrl(ctrl), .result(res_c));
   byte_permute2 #(.OUT_REG(1'b1)) u_byte_permute2_reg (
      .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .ctrl(ctrl), .result(res_r));

   function automatic logic [7:0] getb(input logic [W-1:0] v, input int i);
      return v[(15-i)*8 +: 8];
   endfunction

   function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [W-1:0] c);
      logic [W-1:0] r;
      for (int i = 0; i < 16; i++) begin
         logic [7:0] cb, o;
         cb = getb(c, i);
         if (!cb[7]) o = (cb[4] ? getb(b, int'(cb[3:0])) : getb(a, int'(cb[3:0])));
         else if (!cb[6]) o = 8'h00;
         else if (!cb[5]) o = 8'hFF;
         else o = 8'h80;
         r[(15-i)*8 +: 8] = o;
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] rnd128();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
      @(negedge clk);
      src_a = a; src_b = b; ctrl = c;
      #1;
   endtask

   initial begin
      #(CLK_PERIOD*5000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [W-1:0] a, b, c, exp, c2;
      void'($urandom(seed));
      src_a = '0; src_b = '0; ctrl = '0;
      #(CLK_PERIOD*2 + 1);
      chk("R8 reset", res_r, '0);
      rst_n = 1;

      a = 128'h00112233445566778899AABBCCDDEEFF;
      b = 128'h102132435465768798A9BACBDCEDFE0F;

      // R6 reversal
      for (int i = 0; i < 16; i++) c[(15-i)*8 +: 8] = 8'(15 - i);
      apply(a, b, c);
      exp = 0;
      for (int i = 0; i < 16; i++) exp[(15-i)*8 +: 8] = getb(a, 15 - i);
      chk("R6 reverse", res_c, exp);

      // R7 unaligned windows
      for (int k = 0; k <= 16; k += 4) begin
         for (int i = 0; i < 16; i++) c[(15-i)*8 +: 8] = 8'(k + i);
         apply(a, b, c);
         exp = ({a, b} << (k*8)) >> W;
         chk("R7 window", res_c, exp);
      end

      // R2/R3/R4 constants on every lane, with don't-care low bits
      apply(a, b, {16{8'h9F}}); chk("R2 zero", res_c, '0);
      apply(a, b, {16{8'hC7}}); chk("R3 ones", res_c, {16{8'hFF}});
      apply(a, b, {16{8'hE3}}); chk("R4 half", res_c, {16{8'h80}});

      // R1 bits 6:5 ignored: 0x6F equals 0x0F, picks a[15]
      apply(a, b, {16{8'h6F}}); chk("R1 ignored bits", res_c, {16{getb(a, 15)}});
      apply(a, b, {16{8'h10}}); chk("R1 b first", res_c, {16{getb(b, 0)}});

      // R5 single-lane change
      c = rnd128();
      apply(a, b, c);
      exp = res_c;
      c2 = c; c2[7*8 +: 8] = 8'hC0;
      apply(a, b, c2);
      exp[7*8 +: 8] = 8'hFF;
      chk("R5 lane isolation", res_c, exp);

      // R1 random plus R8 registered latency
      for (int t = 0; t < 200; t++) begin
         a = rnd128(); b = rnd128(); c = rnd128();
         apply(a, b, c);
         exp = model(a, b, c);
         chk("R1 random", res_c, exp);
         @(posedge clk); #1;
         chk("R8 registered", res_r, exp);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule